// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits between an internal clock tree and a set of clock output groups. It gates each group according to three active-low controls: a CPU-side stop, a PCI-side stop and a power-down request. All group clocks are divided from one fast master clock, and the controller runs in that master domain. The divided group waveforms arrive as level inputs. Each control passes through a two-flop synchronizer. A group's gate enable is allowed to change only while that group's raw clock is low. The gated output is then registered on the master clock. As a result, every high pulse that leaves the block has the full width of the raw pulse, and every stopped group rests at a static low.

The CPU stop silences the CPU group and the fixed 66 MHz group. The PCI stop silences PCI outputs 1 to 7, while the free-running PCI output keeps toggling. The half-rate, IOAPIC, reference and 48 MHz groups ignore both stops. Power-down overrides both stops: it drains every group to low and then drops a single enable flag for the oscillator and PLLs.

The sequencer has four states:
- `PM_OFF`: dark. Oscillator and PLLs are disabled.
- `PM_SETTLE`: the oscillator and PLLs are enabled and a counter of `SETTLE_CYC` master cycles runs while all outputs stay low.
- `PM_RUN`: groups are enabled from the current stop inputs.
- `PM_DRAIN`: every request is withdrawn and the sequencer waits for all gates to close.

Transitions:
- OFF goes to SETTLE when power is requested.
- SETTLE goes back to OFF if power-down returns.
- SETTLE goes to RUN when the count expires.
- RUN goes to DRAIN on power-down.
- DRAIN goes to OFF once every enable is clear.

Reset places the sequencer in OFF.

Top module: `clk_stop_ctrl`

## Requirements
- R1: With CPU stop low, the CPU and 66 MHz groups become static low within one PCI clock period (8 master cycles) of the control change. With CPU stop high again, they resume toggling within the same window.
- R2: The half-rate, IOAPIC, reference, 48 MHz and free-running PCI outputs keep toggling whatever the levels of CPU stop and PCI stop, as long as power is on.
- R3: With PCI stop low, PCI outputs 1 to 7 become static low within one PCI period, while the free-running PCI output continues. Releasing PCI stop restarts them within one PCI period.
- R4: With power-down low, every output is static low within two PCI periods (16 master cycles), and `osc_pll_en` is low by then.
- R5: While power-down is low, changes on CPU stop or PCI stop cause no output activity.
- R6: After power-down is released, `osc_pll_en` goes high within 5 master cycles. All outputs stay low for at least `SETTLE_CYC` master cycles after the release, and then the enabled groups toggle.
- R7: Stop levels are taken at the moment of power-up. If CPU stop is already low when the settle interval ends, the CPU and 66 MHz groups stay low while all other groups start.
- R8: Every high pulse on every output has exactly the width of the raw group clock's high phase. No runt or shortened pulse appears at any stop, start or drain.
- R9: While reset is low, and from the first edge of reset onward, all outputs and `osc_pll_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock from which all group clocks are divided |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_raw | input | 1 | Raw CPU group clock |
| m66_raw | input | 1 | Raw fixed 66 MHz group clock |
| pci_raw | input | 1 | Raw PCI clock, shared by PCI 1..7 and the free-running output |
| half_raw | input | 1 | Raw half-CPU-rate clock |
| apic_raw | input | 1 | Raw IOAPIC clock |
| ref_raw | input | 1 | Raw reference clock |
| usb_raw | input | 1 | Raw 48 MHz clock |
| cpu_stop_n | input | 1 | Asynchronous CPU stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI stop, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down, active low |
| cpu_clk | output | N_CPU | Gated CPU clocks |
| m66_clk | output | N_M66 | Gated 66 MHz clocks |
| pci_clk | output | N_PCI | Gated PCI clocks 1..7 |
| pci_free | output | 1 | Free-running PCI clock, stopped only in power-down |
| half_clk | output | N_HALF | Half-CPU-rate clocks |
| apic_clk | output | N_APIC | IOAPIC clocks |
| ref_clk | output | N_REF | Reference clocks |
| usb_clk | output | 1 | 48 MHz clock |
| osc_pll_en | output | 1 | Enable flag for the oscillator and PLLs |

## Verification
The hardest situation to reach is a power-up in which a stop input was changed during power-down and is still low when the settle count expires. The stop must then be honoured from the first enabled cycle, with no stray pulse on the stopped groups. The stimulus reaches it by lowering power-down and waiting for the drain to finish. It then toggles CPU stop while the block is dark, leaves CPU stop low, and releases power-down. Finally it watches both the quiet settle window and the group mix that follows. A separate pulse-width monitor runs through every stop, start, drain and mid-run reset. It catches any truncated first or last pulse.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PM_OFF    = 2'd0,
        PM_SETTLE = 2'd1,
        PM_RUN    = 2'd2,
        PM_DRAIN  = 2'd3
    } pm_state_t;

    localparam int NGRP   = 8;
    localparam int G_CPU  = 0;
    localparam int G_M66  = 1;
    localparam int G_PCI  = 2;
    localparam int G_PCIF = 3;
    localparam int G_HALF = 4;
    localparam int G_APIC = 5;
    localparam int G_REF  = 6;
    localparam int G_USB  = 7;

    // groups that only power-down can stop
    localparam logic [NGRP-1:0] FREE_MASK =
        (NGRP'(1) << G_PCIF) | (NGRP'(1) << G_HALF) | (NGRP'(1) << G_APIC) |
        (NGRP'(1) << G_REF)  | (NGRP'(1) << G_USB);

endpackage

// File: rtl/pm_sync2.sv
module pm_sync2 #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // reset value 0 means every control reads as asserted (stopped, powered down)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic req,
    output logic en,
    output logic gclk
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            gclk <= 1'b0;
        end else begin
            if (!raw) begin
                en <= req;
            end
            gclk <= raw & en;
        end
    end

    // R8
    en_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en) |-> !$past(raw));

endmodule

// File: rtl/pm_seq.sv
module pm_seq
    import pm_pkg::*;
#(
    parameter int SETTLE_CYC = 300000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_ok,
    input  logic            cpu_go,
    input  logic            pci_go,
    input  logic [NGRP-1:0] en_all,
    output logic [NGRP-1:0] req,
    output logic            osc_pll_en
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    pm_state_t state, nxt;
    logic [CW-1:0] cnt;

    // state register and settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PM_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == PM_SETTLE) ? cnt + CW'(1) : '0;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            PM_OFF:    if (pwr_ok) nxt = PM_SETTLE;
            PM_SETTLE: begin
                if (!pwr_ok)          nxt = PM_OFF;
                else if (cnt == LAST) nxt = PM_RUN;
            end
            PM_RUN:    if (!pwr_ok) nxt = PM_DRAIN;
            PM_DRAIN:  if (en_all == '0) nxt = PM_OFF;
            default:   nxt = PM_OFF;
        endcase
    end

    // outputs
    always_comb begin
        req        = '0;
        osc_pll_en = 1'b1;
        unique case (state)
            PM_OFF:    osc_pll_en = 1'b0;
            PM_SETTLE: req = '0;
            PM_RUN: begin
                req        = FREE_MASK;
                req[G_CPU] = cpu_go;
                req[G_M66] = cpu_go;
                req[G_PCI] = pci_go;
            end
            PM_DRAIN:  req = '0;
            default:   osc_pll_en = 1'b0;
        endcase
    end

    // R6
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_SETTLE) |-> (en_all == '0));

    // R2
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN) |=> ((($past(en_all) & ~en_all) & FREE_MASK) == '0));

    // R5
    pd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (state != PM_RUN));

    // R4
    off_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_OFF) |-> (en_all == '0));

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import pm_pkg::*;
#(
    parameter int N_CPU      = 4,
    parameter int N_M66      = 4,
    parameter int N_PCI      = 7,
    parameter int N_HALF     = 2,
    parameter int N_APIC     = 3,
    parameter int N_REF      = 2,
    parameter int SETTLE_CYC = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_raw,
    input  logic              m66_raw,
    input  logic              pci_raw,
    input  logic              half_raw,
    input  logic              apic_raw,
    input  logic              ref_raw,
    input  logic              usb_raw,
    input  logic              cpu_stop_n,
    input  logic              pci_stop_n,
    input  logic              pwr_dn_n,
    output logic [N_CPU-1:0]  cpu_clk,
    output logic [N_M66-1:0]  m66_clk,
    output logic [N_PCI-1:0]  pci_clk,
    output logic              pci_free,
    output logic [N_HALF-1:0] half_clk,
    output logic [N_APIC-1:0] apic_clk,
    output logic [N_REF-1:0]  ref_clk,
    output logic              usb_clk,
    output logic              osc_pll_en
);
    logic [2:0]      ctl_s;
    logic [NGRP-1:0] raw_v, req_v, en_v, gate_v;

    pm_sync2 #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pwr_dn_n, pci_stop_n, cpu_stop_n}),
        .q     (ctl_s)
    );

    pm_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok     (ctl_s[2]),
        .cpu_go     (ctl_s[0]),
        .pci_go     (ctl_s[1]),
        .en_all     (en_v),
        .req        (req_v),
        .osc_pll_en (osc_pll_en)
    );

    assign raw_v[G_CPU]  = cpu_raw;
    assign raw_v[G_M66]  = m66_raw;
    assign raw_v[G_PCI]  = pci_raw;
    assign raw_v[G_PCIF] = pci_raw;
    assign raw_v[G_HALF] = half_raw;
    assign raw_v[G_APIC] = apic_raw;
    assign raw_v[G_REF]  = ref_raw;
    assign raw_v[G_USB]  = usb_raw;

    for (genvar g = 0; g < NGRP; g++) begin : g_gate
        pm_clk_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_v[g]),
            .req   (req_v[g]),
            .en    (en_v[g]),
            .gclk  (gate_v[g])
        );
    end

    assign cpu_clk  = {N_CPU{gate_v[G_CPU]}};
    assign m66_clk  = {N_M66{gate_v[G_M66]}};
    assign pci_clk  = {N_PCI{gate_v[G_PCI]}};
    assign pci_free = gate_v[G_PCIF];
    assign half_clk = {N_HALF{gate_v[G_HALF]}};
    assign apic_clk = {N_APIC{gate_v[G_APIC]}};
    assign ref_clk  = {N_REF{gate_v[G_REF]}};
    assign usb_clk  = gate_v[G_USB];

    // R4
    dark_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_pll_en |-> (gate_v == '0));

endmodule

// File: tb/clk_stop_ctrl_bench.sv
module clk_stop_ctrl_bench;

    localparam int SETTLE = 50;
    localparam int WIN    = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, cpu_stop_n, pci_stop_n, pwr_dn_n;
    logic cpu_raw, m66_raw, pci_raw, half_raw, apic_raw, ref_raw, usb_raw;
    logic [3:0] cpu_clk;
    logic [3:0] m66_clk;
    logic [6:0] pci_clk;
    logic       pci_free;
    logic [1:0] half_clk;
    logic [2:0] apic_clk;
    logic [1:0] ref_clk;
    logic       usb_clk;
    logic       osc_pll_en;

    clk_stop_ctrl #(.SETTLE_CYC(SETTLE)) u_clk_stop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_raw(cpu_raw), .m66_raw(m66_raw), .pci_raw(pci_raw),
        .half_raw(half_raw), .apic_raw(apic_raw), .ref_raw(ref_raw),
        .usb_raw(usb_raw),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .cpu_clk(cpu_clk), .m66_clk(m66_clk), .pci_clk(pci_clk),
        .pci_free(pci_free), .half_clk(half_clk), .apic_clk(apic_clk),
        .ref_clk(ref_clk), .usb_clk(usb_clk), .osc_pll_en(osc_pll_en)
    );

    // divider model; bit order: cpu,m66,pci,pcif,half,apic,ref,usb
    int tick = 0;
    initial begin
        cpu_raw = 0; m66_raw = 0; pci_raw = 0; half_raw = 0;
        apic_raw = 0; ref_raw = 0; usb_raw = 0;
        forever begin
            @(negedge clk);
            tick++;
            cpu_raw  = (tick % 2)  < 1;
            m66_raw  = (tick % 4)  < 2;
            pci_raw  = (tick % 8)  < 4;
            half_raw = (tick % 4)  < 2;
            apic_raw = (tick % 16) < 8;
            ref_raw  = (tick % 18) < 9;
            usb_raw  = (tick % 6)  < 3;
        end
    end

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    function automatic logic [7:0] obs();
        return {usb_clk, |ref_clk, |apic_clk, |half_clk, pci_free,
                |pci_clk, |m66_clk, |cpu_clk};
    endfunction

    typedef struct {
        string      tag;
        logic [7:0] run;
        logic       osc;
    } exp_t;

    exp_t q[$];
    int   sent = 0;
    int   seen = 0;

    task automatic expect_run(input string tag, input logic [7:0] run, input logic osc);
        exp_t it;
        it.tag = tag; it.run = run; it.osc = osc;
        q.push_back(it);
        sent++;
        wait (seen == sent);
    endtask

    // monitor: pop expectation, watch a window, compare
    initial begin
        exp_t it;
        logic [7:0] tog, hi, prev, cur;
        forever begin
            wait (q.size() != 0);
            it = q.pop_front();
            tog = '0; hi = '0;
            prev = obs();
            for (int i = 0; i < WIN; i++) begin
                @(negedge clk);
                cur  = obs();
                tog |= cur ^ prev;
                hi  |= cur;
                prev = cur;
            end
            total++;
            if (((tog & it.run) != it.run) || ((hi & ~it.run) != 8'h00)
                || (osc_pll_en !== it.osc)) begin
                bad++;
                $display("FAIL %s: toggling=%b expected=%b osc=%b expected=%b",
                         it.tag, tog, it.run, osc_pll_en, it.osc);
            end
            seen++;
        end
    end

    // pulse width monitor for R8
    int hc [8];
    int pulses = 0;
    int wbad = 0;
    int hiw [8] = '{1, 2, 4, 4, 2, 8, 9, 3};
    initial begin
        logic [7:0] cur;
        for (int g = 0; g < 8; g++) hc[g] = 0;
        forever begin
            @(negedge clk);
            cur = obs();
            for (int g = 0; g < 8; g++) begin
                if (!rst_n) hc[g] = 0;
                else if (cur[g]) hc[g]++;
                else if (hc[g] != 0) begin
                    pulses++;
                    if (hc[g] != hiw[g]) wbad++;
                    hc[g] = 0;
                end
            end
        end
    end

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R6: quiet settle window after power-up request
    task automatic quiet_window(input string tag);
        logic [7:0] any;
        any = '0;
        for (int i = 0; i < SETTLE; i++) begin
            @(negedge clk);
            any |= obs();
            if (i == 5) check_val({tag, " osc on"}, 32'(osc_pll_en), 32'd1);
        end
        check_val({tag, " quiet"}, 32'(any), 32'd0);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; cpu_stop_n = 1; pci_stop_n = 1; pwr_dn_n = 1;
        wait_cyc(4);
        check_val("R9 reset outputs", 32'(obs()), 32'd0);
        check_val("R9 reset osc", 32'(osc_pll_en), 32'd0);
        rst_n = 1;
        quiet_window("R6 first power-up");
        wait_cyc(15);
        expect_run("R6 all running", 8'hFF, 1'b1);

        cpu_stop_n = 0; wait_cyc(8);
        expect_run("R1 cpu stop", 8'hFC, 1'b1);
        cpu_stop_n = 1; wait_cyc(8);
        expect_run("R1 cpu restart", 8'hFF, 1'b1);

        pci_stop_n = 0; wait_cyc(8);
        expect_run("R3 pci stop", 8'hFB, 1'b1);
        pci_stop_n = 1; wait_cyc(8);
        expect_run("R3 pci restart", 8'hFF, 1'b1);

        cpu_stop_n = 0; pci_stop_n = 0; wait_cyc(8);
        expect_run("R2 both stops", 8'hF8, 1'b1);
        cpu_stop_n = 1; pci_stop_n = 1; wait_cyc(8);

        pwr_dn_n = 0; wait_cyc(16);
        expect_run("R4 power-down", 8'h00, 1'b0);
        cpu_stop_n = 0; pci_stop_n = 0; wait_cyc(4);
        cpu_stop_n = 1; pci_stop_n = 1; wait_cyc(4);
        cpu_stop_n = 0;
        expect_run("R5 stops ignored in power-down", 8'h00, 1'b0);

        pwr_dn_n = 1;
        quiet_window("R6 second power-up");
        wait_cyc(15);
        expect_run("R7 cpu stop held at power-up", 8'hFC, 1'b1);
        cpu_stop_n = 1; wait_cyc(8);
        expect_run("R1 restart after power-up", 8'hFF, 1'b1);

        rst_n = 0; wait_cyc(2);
        check_val("R9 mid-run reset outputs", 32'(obs()), 32'd0);
        check_val("R9 mid-run reset osc", 32'(osc_pll_en), 32'd0);
        rst_n = 1;
        quiet_window("R6 after reset");
        wait_cyc(15);
        expect_run("R9 recovery", 8'hFF, 1'b1);

        total++;
        if (wbad != 0 || pulses < 100) begin
            bad++;
            $display("FAIL R8 pulse widths: bad=%0d pulses=%0d expected bad=0 pulses>=100",
                     wbad, pulses);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule